// File: doc/BRIEF.md
# Period-Match Timer with Prescale and Postscale

An 8-bit up-counter driven by an input clock-enable tick. Each tick is first divided by a selectable prescaler (divide by 1, 4 or 16). The counter then advances on every divided tick. When the counter value equals an 8-bit period register, the counter restarts from zero on that tick and the block emits a one-clock match pulse. The same pulse is driven out of the block, so a serial shifter can use it as its shift clock source.

A 4-bit postscaler counts match events. When it reaches its programmed terminal count, it sets a sticky interrupt flag. Software clears the flag through a dedicated clear input.

A small register interface with a 2-bit select reaches three registers: the count, the period and a control byte. Writing the count register, or writing the control byte, resets both divider chains. The two cases differ in one respect: a control write leaves the count unchanged, while a count write loads the new value. A period write takes effect at the next comparison and disturbs nothing else.

Top module: `pm_timer`

## Requirements
- R1: A synchronous active-high reset sets the following state: count 0x00, period 0xFF, control byte 0x00, interrupt flag 0 and match pulse 0.
- R2: The select codes are 0 for count, 1 for period, 2 for control and 3 for nothing (reads 0). In the control byte, bits 6:3 hold the postscale select, bit 2 holds the run enable and bits 1:0 hold the prescale select. Bit 7 is discarded on write and always reads 0.
- R3: The prescale select values are 00 for divide by 1, 01 for divide by 4, and 10 or 11 for divide by 16. Tick counts that are not a multiple of the divisor leave the remainder pending.
- R4: On a divided tick where count equals period, the count becomes 0. Otherwise the count increments, so one period lasts period+1 divided ticks. A count above the period runs up to 0xFF and rolls over to 0 with no match.
- R5: A wrap drives match_pulse high for exactly the one clock after the wrap edge. During that clock the count reads 0.
- R6: With postscale select N, every (N+1)th match sets irq_flag.
- R7: irq_flag stays set until irq_clr is asserted. If a new set and irq_clr occur in the same cycle, the flag stays set.
- R8: With the run enable at 0, neither the count nor the prescaler advances on ticks.
- R9: A count write loads wr_data into the count and resets the prescaler and the postscaler. No divided tick occurs in the write cycle.
- R10: A control write resets the prescaler and the postscaler but keeps the count.
- R11: A period write resets no counter and applies at the next comparison.
- R12: rd_data is registered: it shows the register chosen by reg_sel at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock-enable tick into the prescaler |
| reg_sel | input | 2 | Register select (0 count, 1 period, 2 control) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| rd_data | output | 8 | Registered read data |
| match_pulse | output | 1 | One-clock pulse after each wrap |
| irq_flag | output | 1 | Sticky postscaled interrupt flag |

## Verification
The hardest states to reach from the ports are partly filled divider chains, because neither the prescaler nor the postscaler count can be read. The bench gets there by running an exact number of enabled clocks that stops one short of a divided tick or a terminal count. It then issues a count or control write and shows that the same number of clocks again yields no new tick or flag, while one more clock does. The set-versus-clear race is produced by raising irq_clr on the same clock as a wrap with a period of zero.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [3:0] post_sel;
    logic       run;
    logic [1:0] pre_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // last prescaler count before a divided tick
  function automatic logic [3:0] pre_last(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd0;
      2'b01:   return 4'd3;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [PRE_W-1:0] last,
  output logic             tick_out
);
  logic [PRE_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == last);
  assign tick_out = tick_in & at_last & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         match_q
);
  logic [W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick & ~load & (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= wrap;
      if (load) begin
        cnt_q <= load_val;
      end else if (tick) begin
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_postscaler.sv
module pm_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              match,
  input  logic [POST_W-1:0] sel,
  input  logic              irq_clr,
  output logic              irq
);
  logic [POST_W-1:0] cnt_q;
  logic              hit;

  assign hit = match & ~clr & (cnt_q == sel);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (match) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (hit) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int PRE_W   = 4,
  parameter int POST_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic [1:0]         reg_sel,
  input  logic               wr_en,
  input  logic [TIMER_W-1:0] wr_data,
  input  logic               irq_clr,
  output logic [TIMER_W-1:0] rd_data,
  output logic               match_pulse,
  output logic               irq_flag
);
  localparam logic [TIMER_W-1:0] PERIOD_RST = '1;

  reg_sel_e          sel;
  ctrl_t             ctrl_q;
  logic [TIMER_W-1:0] period_q;
  logic [TIMER_W-1:0] cnt_w;
  logic              wr_cnt, wr_per, wr_ctrl, div_clr;
  logic              run_w, pre_tick, wrap_w;
  logic [TIMER_W-1:0] rd_next;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_cnt  = wr_en && (sel == SEL_COUNT);
  assign wr_per  = wr_en && (sel == SEL_PERIOD);
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign div_clr = wr_cnt | wr_ctrl;
  assign run_w   = ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_per)  period_q <= wr_data;
    end
  end

  pm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (div_clr),
    .tick_in  (tick_en & run_w),
    .last     (PRE_W'(pre_last(ctrl_q.pre_sel))),
    .tick_out (pre_tick)
  );

  pm_counter #(.W(TIMER_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (pre_tick),
    .load     (wr_cnt),
    .load_val (wr_data),
    .period   (period_q),
    .cnt      (cnt_w),
    .wrap     (wrap_w),
    .match_q  (match_pulse)
  );

  pm_postscaler #(.POST_W(POST_W)) u_post (
    .clk     (clk),
    .rst     (rst),
    .clr     (div_clr),
    .match   (wrap_w),
    .sel     (POST_W'(ctrl_q.post_sel)),
    .irq_clr (irq_clr),
    .irq     (irq_flag)
  );

  always_comb begin
    case (sel)
      SEL_COUNT:  rd_next = cnt_w;
      SEL_PERIOD: rd_next = period_q;
      SEL_CTRL:   rd_next = TIMER_W'(ctrl_q);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pm_timer_checker.sv
module pm_timer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   reg_sel,
  input logic         irq_clr,
  input logic         run,
  input logic [W-1:0] cnt,
  input logic         wrap,
  input logic         match_pulse,
  input logic         irq_flag,
  input logic [W-1:0] rd_data
);
  assert_match_zero_R5: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> (cnt == '0));

  assert_wrap_emits_match_R5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> match_pulse);

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && reg_sel == 2'd0)) |=> $stable(cnt));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(wrap));

  assert_ctrl_keeps_count_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd2) |=> (cnt == $past(cnt)));

  assert_ctrl_msb_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == 2'd2) |=> (rd_data[7] == 1'b0));
endmodule

bind pm_timer pm_timer_checker #(.W(TIMER_W)) u_pm_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .reg_sel     (reg_sel),
  .irq_clr     (irq_clr),
  .run         (run_w),
  .cnt         (cnt_w),
  .wrap        (wrap_w),
  .match_pulse (match_pulse),
  .irq_flag    (irq_flag),
  .rd_data     (rd_data)
);

// File: tb/tb_pm_timer.sv
module tb_pm_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_clr = 1'b0;
  logic [7:0] rd_data;
  logic       match_pulse;
  logic       irq_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_timer dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr),
    .rd_data(rd_data), .match_pulse(match_pulse), .irq_flag(irq_flag)
  );

  typedef struct packed {
    logic [1:0]  pre;
    logic [3:0]  post;
    logic [7:0]  per;
    logic [15:0] n;
    logic [7:0]  cnt;
    logic [7:0]  nmatch;
    logic        irq;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'b00, 4'd0,  8'd4,   16'd7,   8'd2,  8'd1,  1'b1},
    '{2'b01, 4'd1,  8'd2,   16'd30,  8'd1,  8'd2,  1'b1},
    '{2'b10, 4'd0,  8'd1,   16'd40,  8'd0,  8'd1,  1'b1},
    '{2'b11, 4'd0,  8'd3,   16'd40,  8'd2,  8'd0,  1'b0},
    '{2'b00, 4'd2,  8'd3,   16'd8,   8'd0,  8'd2,  1'b0},
    '{2'b00, 4'd15, 8'd0,   16'd16,  8'd0,  8'd16, 1'b1},
    '{2'b00, 4'd15, 8'd0,   16'd15,  8'd0,  8'd15, 1'b0},
    '{2'b00, 4'd0,  8'd255, 16'd300, 8'd44, 8'd1,  1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] s, output int d);
    reg_sel = s;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic run_ticks(input int n, output int m);
    m = 0;
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (match_pulse) m++;
    end
    tick_en = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v, m;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 match", int'(match_pulse), 0);
    check("R1 irq", int'(irq_flag), 0);
    read_reg(2'd0, v); check("R1 count", v, 0);
    read_reg(2'd1, v); check("R1 period", v, 255);
    read_reg(2'd2, v); check("R1 ctrl", v, 0);
    read_reg(2'd3, v); check("R2 unused select", v, 0);

    // Vector table: prescale, postscale, period, run length
    for (int k = 0; k < 8; k++) begin
      write_reg(2'd1, VEC[k].per);
      write_reg(2'd2, {1'b0, VEC[k].post, 1'b1, VEC[k].pre});
      write_reg(2'd0, 8'd0);
      pulse_clr();
      run_ticks(int'(VEC[k].n), m);
      read_reg(2'd0, v);
      check($sformatf("R3 R4 vec%0d count", k), v, int'(VEC[k].cnt));
      check($sformatf("R5 vec%0d matches", k), m, int'(VEC[k].nmatch));
      check($sformatf("R6 vec%0d irq", k), int'(irq_flag), int'(VEC[k].irq));
    end

    // R2 control readback drops bit 7
    write_reg(2'd2, 8'hFF);
    read_reg(2'd2, v); check("R2 ctrl readback", v, 8'h7F);

    // R8 disabled timer holds
    write_reg(2'd2, 8'h00);
    write_reg(2'd0, 8'd0);
    run_ticks(20, m);
    read_reg(2'd0, v); check("R8 count held", v, 0);
    check("R8 no match", m, 0);

    // R10 control write keeps count
    write_reg(2'd1, 8'd255);
    write_reg(2'd2, 8'h04);
    write_reg(2'd0, 8'd0);
    run_ticks(9, m);
    write_reg(2'd2, 8'h04);
    read_reg(2'd0, v); check("R10 count kept", v, 9);

    // R9 count write clears a partly filled prescaler
    write_reg(2'd2, 8'h05);
    write_reg(2'd0, 8'd5);
    run_ticks(3, m);
    write_reg(2'd0, 8'd5);
    run_ticks(3, m);
    read_reg(2'd0, v); check("R9 prescaler cleared", v, 5);
    run_ticks(1, m);
    read_reg(2'd0, v); check("R9 tick after clear", v, 6);
    // R10 control write clears a partly filled prescaler
    run_ticks(3, m);
    write_reg(2'd2, 8'h05);
    run_ticks(3, m);
    read_reg(2'd0, v); check("R10 prescaler cleared", v, 6);
    run_ticks(1, m);
    read_reg(2'd0, v); check("R10 tick after clear", v, 7);

    // R9 / R10 postscaler clear, postscale 1:2, period 0
    write_reg(2'd1, 8'd0);
    write_reg(2'd2, 8'h0C);
    write_reg(2'd0, 8'd0);
    pulse_clr();
    run_ticks(1, m);
    write_reg(2'd0, 8'd0);
    run_ticks(1, m);
    check("R9 postscaler cleared", int'(irq_flag), 0);
    run_ticks(1, m);
    check("R6 second match sets", int'(irq_flag), 1);
    pulse_clr();
    run_ticks(1, m);
    write_reg(2'd2, 8'h0C);
    run_ticks(1, m);
    check("R10 postscaler cleared", int'(irq_flag), 0);
    run_ticks(1, m);
    check("R10 set after clear", int'(irq_flag), 1);

    // R7 sticky flag and set-over-clear
    write_reg(2'd2, 8'h04);
    pulse_clr();
    check("R7 clear", int'(irq_flag), 0);
    tick_en = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; irq_clr = 1'b0;
    check("R7 set wins", int'(irq_flag), 1);
    repeat (5) @(negedge clk);
    check("R7 sticky", int'(irq_flag), 1);
    pulse_clr();
    check("R7 cleared", int'(irq_flag), 0);

    // R11 period write applies at next comparison
    write_reg(2'd1, 8'd10);
    write_reg(2'd0, 8'd0);
    run_ticks(3, m);
    write_reg(2'd1, 8'd3);
    read_reg(2'd0, v); check("R11 count untouched", v, 3);
    run_ticks(1, m);
    check("R11 new period match", m, 1);
    read_reg(2'd0, v); check("R11 wrapped", v, 0);
    write_reg(2'd2, 8'h05);
    write_reg(2'd0, 8'd0);
    run_ticks(2, m);
    write_reg(2'd1, 8'd20);
    run_ticks(2, m);
    read_reg(2'd0, v); check("R11 prescaler kept", v, 1);

    // R12 one-clock read latency
    read_reg(2'd1, v); check("R12 period read", v, 20);
    reg_sel = 2'd0;
    #1;
    check("R12 old data before edge", int'(rd_data), 20);
    @(negedge clk);
    check("R12 new data after edge", int'(rd_data), 1);

    // R4 count above period rolls over without match
    write_reg(2'd2, 8'h04);
    write_reg(2'd1, 8'd10);
    write_reg(2'd0, 8'd250);
    run_ticks(6, m);
    read_reg(2'd0, v); check("R4 rollover count", v, 0);
    check("R4 rollover no match", m, 0);

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    read_reg(2'd1, v); check("R1 period after reset", v, 255);
    read_reg(2'd0, v); check("R1 count after reset", v, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule